// File: doc/BRIEF.md
# Integrating Receive Noise Filter

This block cleans a serial receive line before bit decoding. Narrow noise pulses are removed, and the line's settled level is passed on. The raw line first goes through a flip-flop synchroniser. On every rising edge of the filter clock, the synchronised level is captured as a direction bit. On the following falling edge, a saturating up/down integrator moves one step in that direction: up for a high sample, down for a low one.

A hysteretic output register follows the integrator. It goes high only when the integrator reaches full scale and low only when the integrator reaches zero. At every value in between it keeps its state. A pulse shorter than the full count span therefore never reaches the output. A steady new level appears after the synchroniser latency, one sampling cycle, and the full span of integrator steps.

The block sits between the line receiver and the symbol decoder. It uses one clock and an asynchronous active-low reset.

Top module: `rx_glitch_filter`

## Requirements
- R1: While reset is asserted and right after it is released, rx_filt is 0 and the integrator is at 0. A high line applied right after reset needs the full latency of R2 before rx_filt goes high.
- R2: The line passes through SYNC_STAGES (default 2) rising-edge flip-flops. A further rising-edge register then captures it as the direction bit. With the default 4-bit integrator, a steady change applied just after a rising edge appears on rx_filt after exactly 18 rising edges: 2 synchroniser stages, 1 sample register and 15 integrator steps.
- R3: A captured high moves the integrator up by one and a captured low moves it down by one. The integrator value is the running difference of ups and downs, limited by R5 and R6.
- R4: The integrator and rx_filt change only on the falling clock edge. The step uses the direction captured on the rising edge just before that falling edge.
- R5: At full scale (2^CNT_W-1, which is 15 by default), a further up step leaves the integrator at full scale. It never wraps to 0.
- R6: At 0, a further down step leaves the integrator at 0. It never wraps to full scale.
- R7: rx_filt becomes 1 on the falling edge where the integrator reaches full scale, and it is 1 whenever the integrator is at full scale.
- R8: rx_filt becomes 0 on the falling edge where the integrator reaches 0, and it is 0 whenever the integrator is at 0.
- R9: From a settled low line, a high pulse lasting 1 to 14 clocks leaves rx_filt at 0 throughout.
- R10: From a settled high line, a low pulse lasting 1 to 14 clocks leaves rx_filt at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock. The line is sampled on the rising edge and the integrator steps on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| rx_raw | input | 1 | Raw, unsynchronised receive line. |
| rx_filt | output | 1 | Filtered receive level. |

## Verification
The assertions check the following on every falling edge:
- The integrator's single-step motion and its direction.
- Its refusal to wrap at either end.
- The tie between the output and the integrator extremes.
- That the output changes only at an extreme.

On rising edges they check that the direction bit follows the synchroniser.

Only the bench scenarios can show the behaviour that involves whole pulses and exact timing:
- The exact 18-edge latency.
- That the output changes between a rising edge and the next falling edge.
- The full sweeps of high and low glitches of 1 to 14 clocks.
- A mixed up-down pulse whose arrival time follows from the running count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // One saturating integrator step; top is the full-scale value.
  function automatic int unsigned sat_step(int unsigned cur, logic up, int unsigned top);
    if (up)  return (cur >= top) ? top : cur + 1;
    else     return (cur == 0)   ? 0   : cur - 1;
  endfunction

  // Hysteretic output: set at full scale, clear at zero, hold otherwise.
  function automatic logic hyst_next(logic cur, int unsigned cnt, int unsigned top);
    if (cnt == top) return 1'b1;
    if (cnt == 0)   return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/rxf_integrator.sv
module rxf_integrator #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  import rxf_pkg::*;
  localparam int unsigned TOP = (1 << CNT_W) - 1;

  always_comb cnt_nxt = CNT_W'(sat_step(int'(cnt), dir, TOP));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             level
);
  import rxf_pkg::*;
  localparam int unsigned TOP = (1 << CNT_W) - 1;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= hyst_next(level, int'(cnt_nxt), TOP);
  end
endmodule

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_raw,
  output logic rx_filt
);
  logic             sync_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_raw), .q(sync_q)
  );

  // Rising-edge sample: sets direction for the next falling-edge step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= sync_q;
  end

  rxf_integrator #(.CNT_W(CNT_W)) u_int (
    .clk(clk), .rst_n(rst_n), .dir(dir_q), .cnt(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rxf_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .level(rx_filt)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_q,
  input logic             dir,
  input logic [CNT_W-1:0] cnt,
  input logic             rx_filt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_DIR_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dir == $past(sync_q)); // R2
  AST_STEP_UP: assert property (@(negedge clk) disable iff (!rst_n)
    (dir && cnt != TOP) |=> cnt == $past(cnt) + ONE); // R3
  AST_STEP_DOWN: assert property (@(negedge clk) disable iff (!rst_n)
    (!dir && cnt != '0) |=> cnt == $past(cnt) - ONE); // R3
  AST_NO_WRAP_TOP: assert property (@(negedge clk) disable iff (!rst_n)
    (dir && cnt == TOP) |=> cnt == TOP); // R5
  AST_NO_WRAP_BOT: assert property (@(negedge clk) disable iff (!rst_n)
    (!dir && cnt == '0) |=> cnt == '0); // R6
  AST_SET_AT_TOP: assert property (@(negedge clk) disable iff (!rst_n)
    (cnt == TOP) |-> rx_filt); // R7
  AST_CLR_AT_BOT: assert property (@(negedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !rx_filt); // R8
  AST_HOLD_MID: assert property (@(negedge clk) disable iff (!rst_n)
    !$stable(rx_filt) |-> (cnt == '0 || cnt == TOP)); // R9
endmodule

bind rx_glitch_filter rxf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .dir(dir_q),
  .cnt(cnt_q), .rx_filt(rx_filt)
);

// File: tb/rx_glitch_filter_bench.sv
module rx_glitch_filter_bench;
  localparam int SYNC = 2;
  localparam int SPAN = 15;
  localparam int LAT  = SYNC + 1 + SPAN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_raw = 1'b0;
  logic rx_filt;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  rx_glitch_filter u_rx_glitch_filter (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .rx_filt(rx_filt)
  );

  always #4 clk = ~clk;

  // Advance to 2 ns after the next rising edge (before the falling edge).
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic exp, input string req);
    n_run++;
    if (rx_filt !== exp) begin
      n_fail++;
      $display("FAIL %s: rx_filt actual=%b expected=%b at %0t", req, rx_filt, exp, $time);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, line held high during reset
    rx_raw = 1'b1;
    tick(); tick();
    chk(1'b0, "R1");
    rx_raw = 1'b0;
    tick();
    rst_n = 1'b1;
    chk(1'b0, "R1");
    repeat (5) tick();

    // R1/R2/R4: rise latency from reset state, exact edge
    rx_raw = 1'b1;
    for (int j = 1; j <= LAT + 4; j++) begin
      tick();
      chk(j >= LAT, "R2");
      if (j == LAT - 1) begin
        #3; // just past the falling edge that completes the span
        chk(1'b1, "R4");
      end
    end

    // R5: hold high long (saturate), then fall with full latency
    repeat (40) tick();
    rx_raw = 1'b0;
    for (int j = 1; j <= LAT + 4; j++) begin
      tick();
      chk(j < LAT, "R5");
    end

    // R6: hold low long, rise latency unchanged (no wrap at bottom)
    repeat (40) tick();
    rx_raw = 1'b1;
    for (int j = 1; j <= LAT + 2; j++) begin
      tick();
      chk(j >= LAT, "R6");
    end
    chk(1'b1, "R7");

    // R10: low glitches 1..14 from settled high
    for (int w = 1; w <= SPAN - 1; w++) begin
      repeat (30) tick();
      rx_raw = 1'b0;
      for (int j = 1; j <= w; j++) begin tick(); chk(1'b1, "R10"); end
      rx_raw = 1'b1;
      for (int j = 1; j <= 25; j++) begin tick(); chk(1'b1, "R10"); end
    end

    // R8: return to low
    rx_raw = 1'b0;
    repeat (LAT + 2) tick();
    chk(1'b0, "R8");

    // R9: high glitches 1..14 from settled low
    for (int w = 1; w <= SPAN - 1; w++) begin
      repeat (30) tick();
      rx_raw = 1'b1;
      for (int j = 1; j <= w; j++) begin tick(); chk(1'b0, "R9"); end
      rx_raw = 1'b0;
      for (int j = 1; j <= 25; j++) begin tick(); chk(1'b0, "R9"); end
    end

    // R3: mixed pulse: 10 up, 3 down, then steady up
    repeat (30) tick();
    begin
      int ups = 10;
      int dns = 3;
      int hit = SYNC + 1 + ups + dns + (SPAN - (ups - dns));
      rx_raw = 1'b1;
      for (int j = 1; j <= ups; j++) begin tick(); chk(1'b0, "R3"); end
      rx_raw = 1'b0;
      for (int j = ups + 1; j <= ups + dns; j++) begin tick(); chk(1'b0, "R3"); end
      rx_raw = 1'b1;
      for (int j = ups + dns + 1; j <= hit + 3; j++) begin
        tick();
        chk(j >= hit, "R3");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule